// File: doc/BRIEF.md
# Scrolling Character Address Mapper

This block converts a position on a character display (a digit column and a line number) into the 6-bit address of the character memory cell to fetch at that position. The 64-cell memory can be viewed as a single line of 64 cells, two lines of 32 or four lines of 16. The view is picked by a structure code. Each address is computed combinationally from the digit, the line, the held scroll state and the structure.

The scroll state is held in three registers. The first is a horizontal character offset, moved by single-cycle left and right step pulses. The second is a vertical offset, moved by up and down step pulses. The third is a base address that the host loads. Horizontal movement rotates addresses inside a line, and vertical movement rotates whole lines. Both wrap at the boundaries of the selected structure. When the structure changes, both offsets return to zero. A separate flag tells whether the requested digit lies in the visible window, which is 16 digits for the narrow font and 13 for the wide font.

Top module: `chm_scroll_mapper`

## Requirements
- R1: After reset the horizontal offset, vertical offset and base are all zero and the registered structure is code 2'b00, so `char_addr` equals `digit_idx` whatever the value of `line_idx`.
- R2: The structure codes are 2'b00 for 1 line of 64, 2'b01 for 2 lines of 32, 2'b10 for 4 lines of 16, and 2'b11, which acts like 2'b00. With no scroll and a zero base, `char_addr` = line × length + digit. `digit_idx` starts at 0 for the first digit, and bit 0 of every address is its least significant bit.
- R3: A left step pulse adds one to the horizontal offset, modulo the line length. After one left step, the last digit of a line shows the first address of that line (2x32: line 0, digit 31 gives 00h).
- R4: A right step pulse subtracts one from the horizontal offset, modulo the line length. After one right step, digit 0 shows the last address of its line (1x64 gives 3Fh; 4x16 line 2 gives 2Fh).
- R5: An up step adds one to the vertical offset and a down step subtracts one, modulo the line count. In 4x16, one up step makes line 0 show 10h and line 3 show 00h, and a net down of one makes line 0 show 30h. In 2x32, one up step swaps the two lines.
- R6: While the structure is a single line, vertical steps leave the address mapping unchanged.
- R7: Opposite step pulses raised in the same cycle (left with right, up with down) cancel, and that offset keeps its value.
- R8: A new `cfg_struct` value is registered on the next clock edge. On that edge both offsets are cleared, and any step pulse raised in the same cycle is ignored.
- R9: When `base_load` is high, `base_value` is stored at the next edge. The low column bits of the base add to the digit modulo the line length. The upper bits of the base, taken as a line number, add to the line modulo the line count.
- R10: Values of `digit_idx` and `line_idx` beyond the current line length or line count wrap modulo those sizes.
- R11: `in_window` is high exactly when `digit_idx` < 16 with `font_wide` = 0, or `digit_idx` < 13 with `font_wide` = 1.
- R12: `char_addr` and `in_window` follow changes of `digit_idx`, `line_idx` and `font_wide` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_struct | input | 2 | Display structure code |
| font_wide | input | 1 | 1 selects the wide font and the 13-digit window |
| step_left | input | 1 | Horizontal offset +1 pulse |
| step_right | input | 1 | Horizontal offset -1 pulse |
| step_up | input | 1 | Vertical offset +1 pulse |
| step_down | input | 1 | Vertical offset -1 pulse |
| base_load | input | 1 | Load strobe for the base address |
| base_value | input | 6 | Base address to load |
| digit_idx | input | 6 | Zero-based digit column |
| line_idx | input | 2 | Zero-based line number |
| char_addr | output | 6 | Character memory address |
| in_window | output | 1 | Digit is inside the visible window |

## Verification
The clocked properties rely on two things: the structure code is held steady between deliberate changes, and each step pulse lasts one cycle. The stimulus keeps both. Every input is changed only on the falling edge, steps are raised for exactly one cycle, and each structure change is followed by at least one quiet cycle before the next step. The counter checks also take for granted that the top never presents an increment and a decrement together. The top ensures this by cancelling opposite pulses. The stimulus still drives opposite pulses together on purpose, so the cancel path is covered.

// File: rtl/chm_pkg.sv
package chm_pkg;

   typedef enum logic [1:0] {
      STRUCT_1X     = 2'b00,
      STRUCT_2X     = 2'b01,
      STRUCT_4X     = 2'b10,
      STRUCT_1X_ALT = 2'b11
   } chm_struct_e;

   localparam int unsigned CHM_MAX_LINE_BITS = 2;

   // log2 of the number of lines a structure code selects
   function automatic logic [1:0] line_bits_of(input chm_struct_e s);
      case (s)
         STRUCT_2X: return 2'd1;
         STRUCT_4X: return 2'd2;
         default:   return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/chm_geom.sv
module chm_geom #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LINE_W = 2,
   localparam int unsigned CB_W = $clog2(ADDR_W + 1)
) (
   input  chm_pkg::chm_struct_e mode,
   output logic [ADDR_W-1:0]    col_mask,
   output logic [LINE_W-1:0]    row_mask,
   output logic [CB_W-1:0]      col_bits
);
   import chm_pkg::*;

   if (ADDR_W <= LINE_W) begin : g_bad_width
      $error("chm_geom: ADDR_W must exceed LINE_W");
   end
   if (LINE_W != CHM_MAX_LINE_BITS) begin : g_bad_lines
      $error("chm_geom: LINE_W must match the structure code range");
   end

   logic [ADDR_W-1:0] col_tab [LINE_W+1];
   logic [LINE_W-1:0] row_tab [LINE_W+1];
   logic [CB_W-1:0]   cb_tab  [LINE_W+1];

   for (genvar k = 0; k <= LINE_W; k++) begin : g_tab
      assign col_tab[k] = ADDR_W'((64'd1 << (ADDR_W - k)) - 64'd1);
      assign row_tab[k] = LINE_W'((64'd1 << k) - 64'd1);
      assign cb_tab[k]  = CB_W'(ADDR_W - k);
   end

   logic [1:0] lb;
   assign lb = line_bits_of(mode);

   always_comb begin
      col_mask = '0;
      row_mask = '0;
      col_bits = CB_W'(ADDR_W);
      for (int k = 0; k <= int'(LINE_W); k++) begin
         if (int'(lb) == k) begin
            col_mask = col_tab[k];
            row_mask = row_tab[k];
            col_bits = cb_tab[k];
         end
      end
   end

endmodule

// File: rtl/chm_wrap_ctr.sv
module chm_wrap_ctr #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         inc,
   input  logic         dec,
   input  logic [W-1:0] mask,
   output logic [W-1:0] value
);

   if (W < 1) begin : g_bad_w
      $error("chm_wrap_ctr: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       value <= '0;
      else if (clear)   value <= '0;
      else if (inc)     value <= (value + W'(1)) & mask;
      else if (dec)     value <= (value - W'(1)) & mask;
   end

   AST_CTR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(inc && dec)); // R7

   AST_CTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (value & ~mask) == '0); // R10

   AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> value == '0); // R8

   AST_CTR_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clear) |=> value == (($past(value) + W'(1)) & $past(mask))); // R3

   AST_CTR_STEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !clear) |=> value == (($past(value) - W'(1)) & $past(mask))); // R4

   AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !dec && !clear) |=> $stable(value)); // R7

endmodule

// File: rtl/chm_addr_calc.sv
module chm_addr_calc #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LINE_W = 2,
   localparam int unsigned CB_W = $clog2(ADDR_W + 1)
) (
   input  logic [ADDR_W-1:0] digit,
   input  logic [LINE_W-1:0] line,
   input  logic [ADDR_W-1:0] h_off,
   input  logic [LINE_W-1:0] v_off,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] col_mask,
   input  logic [LINE_W-1:0] row_mask,
   input  logic [CB_W-1:0]   col_bits,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] col_sum;
   logic [LINE_W-1:0] base_row;
   logic [LINE_W-1:0] row_sum;

   always_comb begin
      // power-of-two line lengths: masking after a natural-width add is the modulo
      col_sum  = (digit + base + h_off) & col_mask;
      base_row = LINE_W'(base >> col_bits);
      row_sum  = (line + base_row + v_off) & row_mask;
      addr     = col_sum | (ADDR_W'(row_sum) << col_bits);
   end

endmodule

// File: rtl/chm_scroll_mapper.sv
module chm_scroll_mapper #(
   parameter int unsigned ADDR_W        = 6,
   parameter int unsigned LINE_W        = 2,
   parameter int unsigned NARROW_DIGITS = 16,
   parameter int unsigned WIDE_DIGITS   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_struct,
   input  logic              font_wide,
   input  logic              step_left,
   input  logic              step_right,
   input  logic              step_up,
   input  logic              step_down,
   input  logic              base_load,
   input  logic [ADDR_W-1:0] base_value,
   input  logic [ADDR_W-1:0] digit_idx,
   input  logic [LINE_W-1:0] line_idx,
   output logic [ADDR_W-1:0] char_addr,
   output logic              in_window
);
   import chm_pkg::*;

   localparam int unsigned CB_W = $clog2(ADDR_W + 1);
   localparam logic [ADDR_W:0] NARROW_LIM = (ADDR_W + 1)'(NARROW_DIGITS);
   localparam logic [ADDR_W:0] WIDE_LIM   = (ADDR_W + 1)'(WIDE_DIGITS);

   if (WIDE_DIGITS > NARROW_DIGITS || NARROW_DIGITS > (1 << ADDR_W)) begin : g_bad_window
      $error("chm_scroll_mapper: window sizes out of range");
   end

   chm_struct_e       struct_q;
   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] h_off;
   logic [LINE_W-1:0] v_off;
   logic [ADDR_W-1:0] col_mask;
   logic [LINE_W-1:0] row_mask;
   logic [CB_W-1:0]   col_bits;
   logic              mode_change;
   logic              h_inc, h_dec, v_inc, v_dec;

   assign mode_change = (cfg_struct != struct_q);
   assign h_inc = step_left  & ~step_right;
   assign h_dec = step_right & ~step_left;
   assign v_inc = step_up    & ~step_down;
   assign v_dec = step_down  & ~step_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         struct_q <= STRUCT_1X;
         base_q   <= '0;
      end else begin
         struct_q <= chm_struct_e'(cfg_struct);
         if (base_load) base_q <= base_value;
      end
   end

   chm_geom #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_geom (
      .mode     (struct_q),
      .col_mask (col_mask),
      .row_mask (row_mask),
      .col_bits (col_bits)
   );

   chm_wrap_ctr #(.W(ADDR_W)) u_hctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (mode_change),
      .inc   (h_inc),
      .dec   (h_dec),
      .mask  (col_mask),
      .value (h_off)
   );

   chm_wrap_ctr #(.W(LINE_W)) u_vctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (mode_change),
      .inc   (v_inc),
      .dec   (v_dec),
      .mask  (row_mask),
      .value (v_off)
   );

   chm_addr_calc #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_calc (
      .digit    (digit_idx),
      .line     (line_idx),
      .h_off    (h_off),
      .v_off    (v_off),
      .base     (base_q),
      .col_mask (col_mask),
      .row_mask (row_mask),
      .col_bits (col_bits),
      .addr     (char_addr)
   );

   assign in_window = {1'b0, digit_idx} < (font_wide ? WIDE_LIM : NARROW_LIM);

   AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      base_load |=> base_q == $past(base_value)); // R9

   AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !base_load |=> $stable(base_q)); // R9

   AST_ONE_LINE_NO_V: assert property (@(posedge clk) disable iff (!rst_n)
      (struct_q == STRUCT_1X || struct_q == STRUCT_1X_ALT) |-> v_off == '0); // R6

   AST_CANCEL_H: assert property (@(posedge clk) disable iff (!rst_n)
      (step_left && step_right && !mode_change) |=> $stable(h_off)); // R7

   AST_CANCEL_V: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && step_down && !mode_change) |=> $stable(v_off)); // R7

   AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      mode_change |=> (h_off == '0 && v_off == '0)); // R8

endmodule

// File: tb/chm_scroll_mapper_tb.sv
module chm_scroll_mapper_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cfg_struct = 2'b00;
   logic       font_wide = 1'b0;
   logic       step_left = 1'b0, step_right = 1'b0, step_up = 1'b0, step_down = 1'b0;
   logic       base_load = 1'b0;
   logic [5:0] base_value = '0;
   logic [5:0] digit_idx = '0;
   logic [1:0] line_idx = '0;
   logic [5:0] char_addr;
   logic       in_window;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   chm_scroll_mapper u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_struct(cfg_struct), .font_wide(font_wide),
      .step_left(step_left), .step_right(step_right), .step_up(step_up),
      .step_down(step_down), .base_load(base_load), .base_value(base_value),
      .digit_idx(digit_idx), .line_idx(line_idx), .char_addr(char_addr),
      .in_window(in_window)
   );

   // ---------------- behavioural reference model ----------------
   int m_s = 0, m_h = 0, m_v = 0, m_base = 0;

   function automatic int len_of(input int s);
      if (s == 1) return 32;
      if (s == 2) return 16;
      return 64;
   endfunction

   function automatic int nl_of(input int s);
      return 64 / len_of(s);
   endfunction

   function automatic int exp_addr(input int s, input int d, input int l,
                                   input int h, input int v, input int b);
      int len, nl, col, row;
      len = len_of(s);
      nl  = nl_of(s);
      col = (d + (b % len) + h) % len;
      row = (l + (b / len) + v) % nl;
      return row * len + col;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_s <= 0; m_h <= 0; m_v <= 0; m_base <= 0;
      end else begin
         if (int'(cfg_struct) != m_s) begin
            m_s <= int'(cfg_struct);
            m_h <= 0;
            m_v <= 0;
         end else begin
            m_h <= (m_h + int'(step_left) - int'(step_right) + len_of(m_s)) % len_of(m_s);
            m_v <= (m_v + int'(step_up) - int'(step_down) + nl_of(m_s)) % nl_of(m_s);
         end
         if (base_load) m_base <= int'(base_value);
      end
   end

   // per-cycle comparison in the low phase, away from both edges
   always @(negedge clk) begin
      #3;
      if (rst_n) begin
         int e;
         int w;
         e = exp_addr(m_s, int'(digit_idx), int'(line_idx), m_h, m_v, m_base);
         w = (int'(digit_idx) < (font_wide ? 13 : 16)) ? 1 : 0;
         checks++;
         if (int'(char_addr) != e || int'(in_window) != w) begin
            errors++;
            $display("FAIL model(R2,R12): addr=%h win=%0d expected addr=%h win=%0d",
                     char_addr, in_window, e[5:0], w);
         end
      end
   end

   // ---------------- directed stimulus helpers ----------------
   task automatic chk_addr(input int d, input int l, input int e, input string req);
      @(negedge clk);
      digit_idx = 6'(d);
      line_idx  = 2'(l);
      #1;
      checks++;
      if (int'(char_addr) != e) begin
         errors++;
         $display("FAIL %s: digit=%0d line=%0d addr=%h expected %h", req, d, l, char_addr, e[5:0]);
      end
   endtask

   task automatic chk_win(input logic fw, input int d, input logic e, input string req);
      @(negedge clk);
      font_wide = fw;
      digit_idx = 6'(d);
      #1;
      checks++;
      if (in_window !== e) begin
         errors++;
         $display("FAIL %s: wide=%0d digit=%0d in_window=%0d expected %0d", req, fw, d, in_window, e);
      end
   endtask

   task automatic pulse(input logic l, input logic r, input logic u, input logic d);
      @(negedge clk);
      step_left = l; step_right = r; step_up = u; step_down = d;
      @(negedge clk);
      step_left = 1'b0; step_right = 1'b0; step_up = 1'b0; step_down = 1'b0;
   endtask

   task automatic set_cfg(input logic [1:0] c);
      @(negedge clk);
      cfg_struct = c;
      @(negedge clk);
   endtask

   task automatic load_base(input logic [5:0] b);
      @(negedge clk);
      base_load = 1'b1; base_value = b;
      @(negedge clk);
      base_load = 1'b0;
   endtask

   bit done = 1'b0;

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, single line, line index ignored
      chk_addr(5, 0, 8'h05, "R1");
      chk_addr(5, 2, 8'h05, "R1");

      // R2: plain mapping in each structure
      set_cfg(2'b10);
      chk_addr(15, 3, 8'h3F, "R2");
      chk_addr(0, 1, 8'h10, "R2");
      set_cfg(2'b01);
      chk_addr(0, 1, 8'h20, "R2");
      chk_addr(31, 0, 8'h1F, "R2");
      set_cfg(2'b11);
      chk_addr(40, 1, 8'h28, "R2");
      set_cfg(2'b01);

      // R3: left step in 2x32
      pulse(1, 0, 0, 0);
      chk_addr(31, 0, 8'h00, "R3");
      chk_addr(0, 0, 8'h01, "R3");
      chk_addr(31, 1, 8'h20, "R3");

      // R5: up step swaps the two lines
      pulse(0, 0, 1, 0);
      chk_addr(0, 0, 8'h21, "R5");
      chk_addr(0, 1, 8'h01, "R5");

      // R8: structure change with a simultaneous left step
      @(negedge clk);
      cfg_struct = 2'b00;
      step_left = 1'b1;
      @(negedge clk);
      step_left = 1'b0;
      chk_addr(0, 0, 8'h00, "R8");

      // R4: right step in 1x64
      pulse(0, 1, 0, 0);
      chk_addr(0, 0, 8'h3F, "R4");

      // R6: vertical step in single-line mode
      pulse(0, 0, 1, 0);
      chk_addr(7, 2, 8'h06, "R6");

      // R7: opposite horizontal steps together
      pulse(1, 1, 0, 0);
      chk_addr(7, 0, 8'h06, "R7");

      // R4: right step in 4x16
      set_cfg(2'b10);
      pulse(0, 1, 0, 0);
      chk_addr(0, 2, 8'h2F, "R4");
      chk_addr(1, 2, 8'h20, "R4");
      pulse(1, 0, 0, 0);

      // R5: up and down in 4x16
      pulse(0, 0, 1, 0);
      chk_addr(0, 0, 8'h10, "R5");
      chk_addr(0, 3, 8'h00, "R5");
      pulse(0, 0, 0, 1);
      pulse(0, 0, 0, 1);
      chk_addr(0, 0, 8'h30, "R5");
      pulse(0, 0, 1, 1);
      chk_addr(0, 0, 8'h30, "R7");

      // R9: base address in 4x16 with cleared offsets
      set_cfg(2'b00);
      set_cfg(2'b10);
      load_base(6'h25);
      chk_addr(0, 0, 8'h25, "R9");
      chk_addr(12, 3, 8'h11, "R9");

      // R10: indices beyond the structure wrap
      load_base(6'h00);
      chk_addr(20, 0, 8'h04, "R10");
      set_cfg(2'b01);
      chk_addr(40, 3, 8'h28, "R10");

      // R11: visible window edges
      chk_win(1'b0, 15, 1'b1, "R11");
      chk_win(1'b0, 16, 1'b0, "R11");
      chk_win(1'b1, 12, 1'b1, "R11");
      chk_win(1'b1, 13, 1'b0, "R11");

      // R12: address follows the digit within the same low phase
      chk_addr(3, 0, 8'h03, "R12");
      chk_addr(4, 0, 8'h04, "R12");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule